// File: doc/BRIEF.md
# Hash Result Buffer Nonce Scanner

This block sits behind the read-back path of a hashing chip. Each poll returns a snapshot of 17 32-bit words, one word per accepted beat. Words 0 to 15 are result slots, and word 16 is a job marker that the chip changes when it moves to new work. The block keeps a stored copy of the last accepted snapshot. When the marker differs from the stored one, the block treats the poll as a job switch. Every result slot that changed then holds a raw nonce found for the previous job.

Each changed raw word is unscrambled into a nonce. The block then offers three candidates for it on a valid/ready stream, because the chip's counter can be off by a known amount. A later stage tests the candidates against the real hash, which this block does not do. At the end of every snapshot, the block reports in a one-cycle pulse how many slots produced candidates.

Top module: `nonce_scan`

## Requirements
- R1: After reset, `out_valid` and `done_valid` are low and `in_ready` is high. The stored snapshot is all zero.
- R2: The first complete snapshot after reset produces no candidates and reports a count of 0. It is not stored, so the next snapshot is compared against the all-zero reset contents.
- R3: A job switch exists only when the incoming word 16 differs from the stored word 16. Without a switch, no candidates are produced and the reported count is 0.
- R4: On a job switch with `in_prev_ok` high (sampled with word 16), every slot 0..15 whose new word differs from the stored word produces candidates. Slots are served in ascending order, with `out_slot` giving the slot index. With `in_prev_ok` low, no candidates are produced.
- R5: On a job switch, all 17 stored words are replaced by the new snapshot, whatever the value of `in_prev_ok`. Without a switch, the stored snapshot is left unchanged.
- R6: A raw word r decodes in three steps. First, bits 31:24 take r[7:0]. Second, let v be r[31:8] with the bit order of each of its three bytes reversed. Output bits 21:0 take v[23:2], bit 23 takes v[0] and bit 22 takes v[1]. Third, 0x00800004 is subtracted modulo 2^32.
- R7: For each decoded nonce n, three candidates leave in this order: n - 0x00800000, then n, then n - 0x00400000.
- R8: While `out_valid` is high and `out_ready` is low, `out_nonce` and `out_slot` hold. While candidates of a snapshot are pending, `in_ready` stays low.
- R9: The cycle after word 16 is accepted, `done_valid` pulses for one cycle. `done_count` then carries the number of slots that produce candidates for that snapshot.
- R10: A word accepted with `in_sof` high is word 0 and restarts any partial snapshot. Words offered without `in_sof` outside a snapshot are taken and dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Snapshot word offered |
| in_ready | output | 1 | Block can take a word |
| in_sof | input | 1 | Offered word is word 0 of a snapshot |
| in_word | input | 32 | Snapshot word |
| in_prev_ok | input | 1 | Previous job may yield results (sampled with word 16) |
| out_valid | output | 1 | Candidate offered |
| out_ready | input | 1 | Consumer takes the candidate |
| out_nonce | output | 32 | Candidate nonce |
| out_slot | output | 4 | Slot the candidate came from |
| done_valid | output | 1 | Snapshot finished (one-cycle pulse) |
| done_count | output | 5 | Slots that produced candidates |

## Verification
The bench builds the block with its default 17-word snapshot, which is the only size the decoding targets. That keeps every slot index, the marker comparison and the full 0-to-16 range of the count within reach of the same sweep. About forty consecutive snapshots mix changed-slot patterns, markers that stay the same, a low previous-job flag, stray words before a frame start and a restarted partial frame. Raw values with all-zero, all-one and single-bit bytes exercise the bit reversal and the borrow of the subtraction. A pseudo-random `out_ready` stalls the stream so that holding and input blocking are seen mid-emission.

// File: rtl/nonce_scan.sv
module nonce_scan #(
  parameter int WORDS = 17
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic        in_sof,
  input  logic [31:0] in_word,
  input  logic        in_prev_ok,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_nonce,
  output logic [$clog2(WORDS-1)-1:0] out_slot,
  output logic        done_valid,
  output logic [$clog2(WORDS)-1:0]   done_count
);
  localparam int SLOTS = WORDS - 1;
  localparam int PW = $clog2(WORDS);
  localparam int SW = $clog2(SLOTS);
  localparam int CW = $clog2(SLOTS + 1);

  logic [31:0]    old_q [WORDS];
  logic [31:0]    new_q [SLOTS];
  logic [SLOTS-1:0] diff_q;
  logic [PW-1:0]  pos_q;
  logic           in_frame_q, seen_q, emit_q;
  logic [SW-1:0]  idx_q;
  logic [1:0]     var_q;
  logic           done_valid_q;
  logic [CW-1:0]  done_count_q;

  function automatic logic [31:0] unscramble(input logic [31:0] r);
    logic [23:0] v;
    for (int b = 0; b < 3; b++)
      for (int k = 0; k < 8; k++)
        v[8*b+k] = r[8 + 8*b + 7 - k];
    return {r[7:0], v[0], v[1], v[23:2]} - 32'h0080_0004;
  endfunction

  logic [PW-1:0] cur;
  logic take, last_w, sw, fire, advance;
  logic [CW-1:0] popcnt;
  logic [31:0] base, offs;

  assign in_ready = !emit_q;
  assign take     = in_valid && in_ready && (in_sof || in_frame_q);
  assign cur      = in_sof ? '0 : pos_q;
  assign last_w   = take && (cur == PW'(SLOTS));
  assign sw       = in_word != old_q[SLOTS];
  assign fire     = last_w && seen_q && sw && in_prev_ok;

  always_comb begin
    popcnt = '0;
    for (int i = 0; i < SLOTS; i++) popcnt = popcnt + CW'(diff_q[i]);
  end

  assign base = unscramble(old_q[PW'(idx_q)]);
  always_comb begin
    case (var_q)
      2'd0:    offs = 32'h0080_0000;
      2'd2:    offs = 32'h0040_0000;
      default: offs = 32'h0;
    endcase
  end

  assign out_valid  = emit_q && diff_q[idx_q];
  assign out_nonce  = base - offs;
  assign out_slot   = idx_q;
  assign done_valid = done_valid_q;
  assign done_count = done_count_q;
  assign advance    = emit_q && (!diff_q[idx_q] || (out_ready && var_q == 2'd2));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) old_q[i] <= '0;
      for (int i = 0; i < SLOTS; i++) new_q[i] <= '0;
      diff_q       <= '0;
      pos_q        <= '0;
      in_frame_q   <= 1'b0;
      seen_q       <= 1'b0;
      emit_q       <= 1'b0;
      idx_q        <= '0;
      var_q        <= '0;
      done_valid_q <= 1'b0;
      done_count_q <= '0;
    end else begin
      done_valid_q <= 1'b0;
      if (take) begin
        in_frame_q <= !last_w;
        pos_q      <= cur + 1'b1;
        if (!last_w) begin
          new_q[cur[SW-1:0]]  <= in_word;
          diff_q[cur[SW-1:0]] <= in_word != old_q[cur];
        end else begin
          seen_q       <= 1'b1;
          done_valid_q <= 1'b1;
          done_count_q <= fire ? popcnt : '0;
          if (seen_q && sw) begin
            for (int i = 0; i < SLOTS; i++) old_q[i] <= new_q[i];
            old_q[SLOTS] <= in_word;
          end
          if (fire && |diff_q) begin
            emit_q <= 1'b1;
            idx_q  <= '0;
            var_q  <= '0;
          end
        end
      end
      if (advance) begin
        var_q <= '0;
        if (idx_q == SW'(SLOTS - 1)) emit_q <= 1'b0;
        else idx_q <= idx_q + 1'b1;
      end else if (out_valid && out_ready) begin
        var_q <= var_q + 1'b1;
      end
    end
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_nonce) && $stable(out_slot));

  assert_variant_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && var_q == 2'd0 |=>
      out_valid && out_nonce == $past(out_nonce) + 32'h0080_0000);

  assert_first_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seen_q) |-> done_valid && done_count == '0 && !out_valid);

  assert_count_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> done_count <= CW'(SLOTS));

  assert_no_take_while_emit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> $stable(done_valid) || !done_valid);
endmodule

// File: tb/nonce_scan_test.sv
module nonce_scan_test;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_sof = 0, in_prev_ok = 0, out_ready = 0;
  logic [31:0] in_word = 0;
  logic in_ready, out_valid, done_valid;
  logic [31:0] out_nonce;
  logic [3:0] out_slot;
  logic [4:0] done_count;

  nonce_scan uut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sof(in_sof), .in_word(in_word), .in_prev_ok(in_prev_ok), .out_valid(out_valid),
    .out_ready(out_ready), .out_nonce(out_nonce), .out_slot(out_slot),
    .done_valid(done_valid), .done_count(done_count));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  logic [31:0] m_old [17];
  bit m_seen = 0;
  logic [31:0] exp_n [$];
  int exp_s [$];
  int exp_d [$];
  logic [15:0] lfsr = 16'hACE1;

  function automatic logic [31:0] ref_dec(input logic [31:0] r);
    logic [31:0] x, y;
    x = r >> 8;
    x = ((x & 32'h00AAAAAA) >> 1) | ((x & 32'h00555555) << 1);
    x = ((x & 32'h00CCCCCC) >> 2) | ((x & 32'h00333333) << 2);
    x = ((x & 32'h00F0F0F0) >> 4) | ((x & 32'h000F0F0F) << 4);
    y = {r[7:0], 24'h0} | ((x >> 2) & 32'h003FFFFF) | ((x & 1) << 23) | ((x & 2) << 21);
    return y - 32'h0080_0004;
  endfunction

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready <= (lfsr[2:0] != 3'd0) && (lfsr[5:3] != 3'd1);
  end

  always @(negedge clk) if (rst_n) begin
    if (out_valid && out_ready) begin
      if (exp_n.size() == 0) check(0, "R4 unexpected candidate", out_nonce, 0);
      else begin
        logic [31:0] en; int es;
        en = exp_n.pop_front(); es = exp_s.pop_front();
        check(out_nonce == en, "R4 R6 R7 nonce", out_nonce, en);
        check(out_slot == es[3:0], "R4 slot", {28'h0, out_slot}, es);
      end
    end
    if (done_valid) begin
      if (exp_d.size() == 0) check(0, "R9 R10 unexpected done", {27'h0, done_count}, 0);
      else begin
        int ed;
        ed = exp_d.pop_front();
        check(done_count == ed[4:0], "R2 R3 R9 count", {27'h0, done_count}, ed);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic put(input logic [31:0] w, input bit sof, input bit pok);
    @(negedge clk);
    in_valid = 1; in_sof = sof; in_word = w; in_prev_ok = pok;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic model(input logic [31:0] w [17], input bit pok);
    int cnt = 0;
    if (!m_seen) m_seen = 1;
    else if (w[16] != m_old[16]) begin
      if (pok)
        for (int i = 0; i < 16; i++)
          if (w[i] != m_old[i]) begin
            logic [31:0] n;
            n = ref_dec(w[i]);
            exp_n.push_back(n - 32'h0080_0000); exp_s.push_back(i);
            exp_n.push_back(n);                 exp_s.push_back(i);
            exp_n.push_back(n - 32'h0040_0000); exp_s.push_back(i);
            cnt++;
          end
      for (int i = 0; i < 17; i++) m_old[i] = w[i];
    end
    exp_d.push_back(cnt);
  endtask

  task automatic drain();
    @(negedge clk); in_valid = 0; in_sof = 0;
    repeat (3) @(negedge clk);
    while (!in_ready) @(negedge clk);
    repeat (2) @(negedge clk);
    check(exp_n.size() == 0, "R4 R8 missing candidates", exp_n.size(), 0);
    check(exp_d.size() == 0, "R9 missing done", exp_d.size(), 0);
  endtask

  task automatic frame(input logic [31:0] w [17], input bit pok);
    model(w, pok);
    for (int i = 0; i < 17; i++) put(w[i], i == 0, pok);
    drain();
  endtask

  logic [31:0] fw [17];
  logic [31:0] keep [17];

  initial begin
    for (int i = 0; i < 17; i++) m_old[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!out_valid && !done_valid && in_ready, "R1 reset outputs",
          {out_valid, done_valid, in_ready}, 3'b001);

    // R10: stray words outside a frame are dropped
    for (int i = 0; i < 20; i++) put(32'h1111_0000 + i, 0, 1);
    drain();

    // R2: first frame silent and not stored
    for (int i = 0; i < 17; i++) fw[i] = 32'h5A00_0000 + i;
    frame(fw, 1);
    // compared to zeros: switch, every slot changed
    frame(fw, 1);

    // R6 corner raw values
    for (int i = 0; i < 17; i++) fw[i] = m_old[i];
    fw[0] = 32'h0; fw[1] = 32'hFFFF_FFFF; fw[2] = 32'h0000_0001; fw[3] = 32'h0000_0100;
    fw[4] = 32'h0001_0000; fw[5] = 32'h0100_0000; fw[6] = 32'h8000_0000; fw[7] = 32'h0000_0300;
    fw[8] = 32'h0080_0004; fw[16] = 32'hC0DE_0001;
    frame(fw, 1);

    // sweep of changed-slot patterns, no-switch frames and prev_ok low
    for (int m = 0; m < 40; m++) begin
      logic [15:0] pat;
      bit pok;
      pat = 16'(m * 32'h9E37 ^ (m << 3) ^ (1 << (m % 16)));
      pok = (m % 5) != 3;
      for (int i = 0; i < 17; i++) fw[i] = m_old[i];
      for (int i = 0; i < 16; i++)
        if (pat[i]) fw[i] = m_old[i] ^ (32'h0100_0001 * (m + 1) + 32'h0001_0203 * i);
      if (m % 7 != 2) fw[16] = m_old[16] + 32'd1;
      if (m == 0) for (int i = 0; i < 17; i++) keep[i] = fw[i];
      frame(fw, pok);
    end

    // R5: a no-switch frame leaves the store; a switch frame equal in slots yields nothing
    for (int i = 0; i < 17; i++) fw[i] = m_old[i] ^ 32'h00FF_0000;
    fw[16] = m_old[16];
    frame(fw, 1);
    for (int i = 0; i < 16; i++) fw[i] = m_old[i];
    fw[16] = m_old[16] ^ 32'h1;
    frame(fw, 1);

    // R10: partial frame restarted by a new frame start
    for (int i = 0; i < 6; i++) put(32'hDEAD_0000 + i, i == 0, 1);
    for (int i = 0; i < 17; i++) fw[i] = m_old[i] + 32'h0003_0507;
    model(fw, 1);
    for (int i = 0; i < 17; i++) put(fw[i], i == 0, 1);
    drain();

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule